// File: doc/BRIEF.md
# External Interrupt Input Unit

This block takes four asynchronous external interrupt pins and turns them into clean interrupt requests. Each pin is brought into the clock domain through a two-flop synchronizer. It is then read according to a per-pin sense code as an active-high level, an active-low level, a rising edge or a falling edge. Edge events are held in a sticky latch until software clears it. Level requests follow the synchronized pin with no storage.

A single 32-bit control word sets every pin's sense code and enable bit, a master enable, and a routing bit for the critical output. Writing the word also fires one-shot clear strobes for latched edges. The word is written and read over a plain synchronous port: one write strobe and a read bus that is always valid. Pin 0 drives the critical request. Pins 1 to 3 drive the three main-group request lines. Priority encoding and delivery to a processor happen downstream.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset the control word reads as zero and every request output is low.
- R2: Control bits read back as written: sense codes at bits 23:16, master enable at bit 12, pin enables at bits 11:8 and critical routing at bit 0. Bits 27:24 (the clear strobes) and every other bit read as 0.
- R3: Sense code 0 (pin n's field at bits 23-2n:22-2n) makes the request follow the synchronized pin, active high.
- R4: Sense code 3 makes the request follow the inverted synchronized pin, active low.
- R5: With sense code 1, a rising edge sets a sticky event that keeps the request high after the pin returns low.
- R6: With sense code 2, a falling edge sets the sticky event. A rising edge does not.
- R7: Writing 1 to bit 27-n clears pin n's latched edge event. The events of the other pins are unaffected.
- R8: In the level modes (codes 0 and 3) a clear strobe has no effect on the request.
- R9: If a new edge is detected in the same cycle as its clear strobe, the event stays set.
- R10: Pin n's enable at bit 11-n masks its request. An edge latched while the pin is disabled appears once it is enabled.
- R11: When master enable bit 12 is 0, all request outputs are low.
- R12: Pin 0 drives crit_irq_o only when bit 0 is 1, and never drives a main line. Pin n (1 to 3) drives main_irq_o[n-1].
- R13: A level change on a pin reaches the request outputs after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word write data |
| ctrl_rdata_o | output | 32 | Control word read data |
| pin_i | input | 4 | Asynchronous external interrupt pins |
| crit_irq_o | output | 1 | Critical request from pin 0 |
| main_irq_o | output | 3 | Main-group requests from pins 1 to 3 |

## Verification
A new edge can arrive at the latch in the same cycle that software writes the clear strobe for that pin. The bench counts the two synchronizer stages and the edge-detect flop, so it knows in which cycle the latch will set. It then asserts the write carrying the clear bit exactly at that edge. After the write it expects the request to stay high, because the fresh event must survive the clear. A separate clear written later, while no edge is arriving, must drop the request.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NUM_PINS   = 4;
  localparam int CTRL_W     = 32;
  localparam int SENSE_W    = 2;
  // pin n fields sit at TOP - n (or TOP - 2n for sense); hardware decodes these
  localparam int EN_TOP     = 11;
  localparam int CLR_TOP    = 27;
  localparam int SENSE_TOP  = 23;
  localparam int MASTER_BIT = 12;
  localparam int ROUTE_BIT  = 0;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LVL_HI = 2'd0,
    SENSE_RISE   = 2'd1,
    SENSE_FALL   = 2'd2,
    SENSE_LVL_LO = 2'd3
  } sense_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [CTRL_W-1:0]                 wdata_i,
  output logic [CTRL_W-1:0]                 rdata_o,
  output logic [NUM_PINS-1:0][SENSE_W-1:0]  sense_o,
  output logic [NUM_PINS-1:0]               en_o,
  output logic                              master_o,
  output logic                              route_o,
  output logic [NUM_PINS-1:0]               clr_o
);
  logic [NUM_PINS-1:0][SENSE_W-1:0] sense_q;
  logic [NUM_PINS-1:0]              en_q;
  logic                             master_q, route_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= 1'b0;
      route_q  <= 1'b0;
    end else if (we_i) begin
      master_q <= wdata_i[MASTER_BIT];
      route_q  <= wdata_i[ROUTE_BIT];
    end
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    localparam int SENSE_LSB = SENSE_TOP - 2*n - 1;
    localparam int EN_POS    = EN_TOP - n;
    localparam int CLR_POS   = CLR_TOP - n;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sense_q[n] <= '0;
        en_q[n]    <= 1'b0;
      end else if (we_i) begin
        sense_q[n] <= wdata_i[SENSE_LSB +: SENSE_W];
        en_q[n]    <= wdata_i[EN_POS];
      end
    end

    // strobe lives only in the write cycle, never stored
    assign clr_o[n] = we_i & wdata_i[CLR_POS];
  end

  always_comb begin
    rdata_o             = '0;
    rdata_o[MASTER_BIT] = master_q;
    rdata_o[ROUTE_BIT]  = route_q;
    for (int n = 0; n < NUM_PINS; n++) begin
      rdata_o[SENSE_TOP - 2*n - 1 +: SENSE_W] = sense_q[n];
      rdata_o[EN_TOP - n]                     = en_q[n];
    end
  end

  assign sense_o  = sense_q;
  assign en_o     = en_q;
  assign master_o = master_q;
  assign route_o  = route_q;

  AST_RDATA_TRACKS_WRITE_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[EN_TOP] == $past(wdata_i[EN_TOP])) else $error("en readback"); // R2
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pin_s_i,
  input  logic [SENSE_W-1:0] sense_i,
  input  logic               clr_i,
  output logic               req_o
);
  sense_e sense;
  logic   prev_q, lat_q, lat_d;
  logic   edge_mode, hit;

  assign sense     = sense_e'(sense_i);
  assign edge_mode = (sense == SENSE_RISE) || (sense == SENSE_FALL);

  always_comb begin
    case (sense)
      SENSE_RISE: hit = pin_s_i & ~prev_q;
      SENSE_FALL: hit = ~pin_s_i & prev_q;
      default:    hit = 1'b0;
    endcase
  end

  // new edge beats a simultaneous clear
  always_comb begin
    if (!edge_mode)  lat_d = 1'b0;
    else if (hit)    lat_d = 1'b1;
    else if (clr_i)  lat_d = 1'b0;
    else             lat_d = lat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= pin_s_i;
      lat_q  <= lat_d;
    end
  end

  always_comb begin
    case (sense)
      SENSE_LVL_HI: req_o = pin_s_i;
      SENSE_LVL_LO: req_o = ~pin_s_i;
      default:      req_o = lat_q;
    endcase
  end

  AST_EVENT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q && edge_mode && !clr_i |=> lat_q) else $error("event lost"); // R5
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q && clr_i && !hit |=> !lat_q) else $error("clear ignored"); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> lat_q) else $error("edge lost"); // R9
  AST_LEVEL_NO_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_mode |=> !lat_q || edge_mode) else $error("level latch"); // R8
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import ext_irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctrl_we_i,
  input  logic [CTRL_W-1:0]   ctrl_wdata_i,
  output logic [CTRL_W-1:0]   ctrl_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic                crit_irq_o,
  output logic [NUM_PINS-2:0] main_irq_o
);
  logic [NUM_PINS-1:0][SENSE_W-1:0] sense;
  logic [NUM_PINS-1:0]              en, clr, pin_s, req, gated;
  logic                             master, route;

  ext_irq_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctrl_we_i),
    .wdata_i  (ctrl_wdata_i),
    .rdata_o  (ctrl_rdata_o),
    .sense_o  (sense),
    .en_o     (en),
    .master_o (master),
    .route_o  (route),
    .clr_o    (clr)
  );

  ext_irq_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_det
    ext_irq_detect u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_s_i (pin_s[n]),
      .sense_i (sense[n]),
      .clr_i   (clr[n]),
      .req_o   (req[n])
    );
    assign gated[n] = req[n] & en[n] & master;
  end

  assign crit_irq_o = gated[0] & route;
  assign main_irq_o = gated[NUM_PINS-1:1];

  AST_MASTER_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rdata_o[MASTER_BIT] |-> !crit_irq_o && main_irq_o == '0) else $error("master"); // R11
  AST_ROUTE_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rdata_o[ROUTE_BIT] |-> !crit_irq_o) else $error("route"); // R12
  AST_DISABLED_PIN1_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rdata_o[EN_TOP-1] |-> !main_irq_o[0]) else $error("enable"); // R10
endmodule

// File: tb/tb_ext_irq_unit.sv
module tb_ext_irq_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [31:0] ctrl_wdata_i = '0;
  logic [31:0] ctrl_rdata_o;
  logic [3:0]  pin_i = '0;
  logic        crit_irq_o;
  logic [2:0]  main_irq_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ext_irq_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i), .ctrl_rdata_o(ctrl_rdata_o),
    .pin_i(pin_i), .crit_irq_o(crit_irq_o), .main_irq_o(main_irq_o)
  );

  function automatic logic [3:0] irqs();
    return {main_irq_o, crit_irq_o};
  endfunction

  // code for every pin, enables by pin index, clears by pin index
  function automatic logic [31:0] mk(logic [1:0] code, logic [3:0] en, logic master,
                                     logic route, logic [3:0] clr);
    logic [31:0] v = '0;
    for (int n = 0; n < 4; n++) begin
      v[23-2*n -: 2] = code;
      v[11-n]        = en[n];
      v[27-n]        = clr[n];
    end
    v[12] = master;
    v[0]  = route;
    return v;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [31:0] v);
    ctrl_we_i = 1'b1;
    ctrl_wdata_i = v;
    @(posedge clk_i);
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(ctrl_rdata_o, 32'h0, "R1 rdata");
    chk({28'h0, irqs()}, 32'h0, "R1 outputs");
  endtask

  task automatic t_readback();
    wr(32'hFFFF_FFFF);
    chk(ctrl_rdata_o, 32'h00FF_1F01, "R2 readback");
    wr(32'h0);
    chk(ctrl_rdata_o, 32'h0, "R2 cleared");
  endtask

  task automatic t_sync_level_hi();
    pin_i = 4'b0000;
    wr(mk(2'd0, 4'hF, 1'b1, 1'b1, 4'h0));
    idle(3);
    chk({28'h0, irqs()}, 32'h0, "R3 idle low");
    pin_i = 4'b0001;
    @(posedge clk_i); @(negedge clk_i);
    chk({31'h0, crit_irq_o}, 32'h0, "R13 one edge");
    @(posedge clk_i); @(negedge clk_i);
    chk({31'h0, crit_irq_o}, 32'h1, "R13 two edges");
    pin_i = 4'b0101;
    idle(3);
    chk({28'h0, irqs()}, 32'h5, "R3 follow high");
    pin_i = 4'b0000;
    idle(3);
    chk({28'h0, irqs()}, 32'h0, "R3 follow low");
  endtask

  task automatic t_level_lo();
    wr(mk(2'd3, 4'hF, 1'b1, 1'b1, 4'h0));
    idle(1);
    chk({28'h0, irqs()}, 32'hF, "R4 pins low");
    pin_i = 4'b1111;
    idle(3);
    chk({28'h0, irqs()}, 32'h0, "R4 pins high");
    pin_i = 4'b0000;
    idle(3);
  endtask

  task automatic t_rise_and_clear();
    wr(mk(2'd1, 4'hF, 1'b1, 1'b1, 4'hF));
    idle(2);
    chk({28'h0, irqs()}, 32'h0, "R5 no event");
    pin_i = 4'b1111;
    idle(4);
    chk({28'h0, irqs()}, 32'hF, "R5 rise latched");
    pin_i = 4'b0000;
    idle(4);
    chk({28'h0, irqs()}, 32'hF, "R5 sticky after release");
    wr(mk(2'd1, 4'hF, 1'b1, 1'b1, 4'b0100));
    chk({28'h0, irqs()}, 32'hB, "R7 clear pin2 only");
    chk(ctrl_rdata_o & 32'h0F00_0000, 32'h0, "R2 clear bits read 0");
    wr(mk(2'd1, 4'hF, 1'b1, 1'b1, 4'hF));
    chk({28'h0, irqs()}, 32'h0, "R7 clear all");
  endtask

  task automatic t_fall();
    wr(mk(2'd2, 4'hF, 1'b1, 1'b1, 4'hF));
    pin_i = 4'b1111;
    idle(4);
    chk({28'h0, irqs()}, 32'h0, "R6 rise ignored");
    pin_i = 4'b0000;
    idle(4);
    chk({28'h0, irqs()}, 32'hF, "R6 fall latched");
    wr(mk(2'd2, 4'hF, 1'b1, 1'b1, 4'hF));
    chk({28'h0, irqs()}, 32'h0, "R7 fall cleared");
  endtask

  task automatic t_level_clear();
    wr(mk(2'd0, 4'hF, 1'b1, 1'b1, 4'h0));
    pin_i = 4'b1111;
    idle(3);
    wr(mk(2'd0, 4'hF, 1'b1, 1'b1, 4'hF));
    chk({28'h0, irqs()}, 32'hF, "R8 clear ignored in level");
    pin_i = 4'b0000;
    idle(3);
  endtask

  task automatic t_collide();
    wr(mk(2'd1, 4'hF, 1'b1, 1'b1, 4'hF));
    idle(2);
    pin_i = 4'b0010;
    @(posedge clk_i); @(negedge clk_i);
    @(posedge clk_i); @(negedge clk_i);
    // latch sets on the next edge: clear lands there too
    ctrl_we_i = 1'b1;
    ctrl_wdata_i = mk(2'd1, 4'hF, 1'b1, 1'b1, 4'hF);
    @(posedge clk_i); @(negedge clk_i);
    ctrl_we_i = 1'b0;
    chk({28'h0, irqs()}, 32'h2, "R9 edge beats clear");
    wr(mk(2'd1, 4'hF, 1'b1, 1'b1, 4'hF));
    chk({28'h0, irqs()}, 32'h0, "R9 later clear works");
    pin_i = 4'b0000;
    idle(3);
  endtask

  task automatic t_enable();
    wr(mk(2'd1, 4'b0101, 1'b1, 1'b1, 4'hF));
    pin_i = 4'b1111;
    idle(4);
    chk({28'h0, irqs()}, 32'h5, "R10 disabled masked");
    wr(mk(2'd1, 4'hF, 1'b1, 1'b1, 4'h0));
    chk({28'h0, irqs()}, 32'hF, "R10 held while disabled");
    pin_i = 4'b0000;
    idle(3);
    wr(mk(2'd1, 4'hF, 1'b1, 1'b1, 4'hF));
  endtask

  task automatic t_master();
    wr(mk(2'd0, 4'hF, 1'b0, 1'b1, 4'h0));
    pin_i = 4'b1111;
    idle(3);
    chk({28'h0, irqs()}, 32'h0, "R11 master off");
    wr(mk(2'd0, 4'hF, 1'b1, 1'b1, 4'h0));
    chk({28'h0, irqs()}, 32'hF, "R11 master on");
    pin_i = 4'b0000;
    idle(3);
  endtask

  task automatic t_route();
    wr(mk(2'd0, 4'hF, 1'b1, 1'b0, 4'h0));
    pin_i = 4'b0001;
    idle(3);
    chk({28'h0, irqs()}, 32'h0, "R12 route off");
    wr(mk(2'd0, 4'hF, 1'b1, 1'b1, 4'h0));
    chk({28'h0, irqs()}, 32'h1, "R12 route on");
    pin_i = 4'b1000;
    idle(3);
    chk({28'h0, irqs()}, 32'h8, "R12 pin3 to main2");
    pin_i = 4'b0000;
    idle(3);
  endtask

  initial begin
    #(CLK_PERIOD * 200_000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    idle(2);
    t_reset();
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_readback();
    t_sync_level_hi();
    t_level_lo();
    t_rise_and_clear();
    t_fall();
    t_level_clear();
    t_collide();
    t_enable();
    t_master();
    t_route();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule